// File: doc/BRIEF.md
# Transfer-Snooping Accumulator with Atomic Register Aliases

This block watches the data words that a DMA engine moves and folds each
selected word into a 32-bit accumulator. One mode adds the word into the
accumulator. The other mode runs one CRC32 step per word. A word counts only
when three things hold: the block is enabled, the word comes from the bound
channel, and that transfer's own descriptor asked for snooping.

Both the control register and the accumulator can be written in four ways:
- a plain store;
- an XOR store, which toggles the bits of the mask;
- a SET store, which ORs the mask in;
- a CLEAR store, which clears the bits of the mask.

A copy engine that can only move words can therefore build OR, AND, XOR, NOT,
negation, addition and shifts out of plain copies. Reads of the accumulator
can return it bit-inverted, bit-reversed, or both.

Top module: `snoop_accum`

## Requirements
- R1: After a synchronous reset, the control register and the accumulator both read as zero.
- R2: A plain store sets a register to the written value. Stores go to byte offset 0x434 for control and 0x438 for the accumulator, with address bits 13:12 equal to 00. A seed written to the accumulator is stored unchanged.
- R3: A store with address bits 13:12 equal to 10 (base + 0x2000) ORs the written mask into the addressed register.
- R4: A store with address bits 13:12 equal to 11 (base + 0x3000) clears the bits that are set in the mask.
- R5: A store with address bits 13:12 equal to 01 (base + 0x1000) toggles the bits that are set in the mask. A mask of all ones therefore yields the bitwise NOT.
- R6: With calc field control[8:5] = 0xF, each qualifying word is added modulo 2^32 into the accumulator. Inverting the accumulator and then snooping the word 1 gives its two's-complement negative.
- R7: With calc field 0x0, each qualifying word performs one single-cycle CRC32 step. The step uses polynomial 0x04C11DB7, feeds the data MSB first, and applies no reflection and no final XOR.
- R8: A transfer qualifies only in these conditions: enable bit control[0] is 1, xfer_chan equals channel field control[4:1], and xfer_sniff is 1. Any other transfer leaves the accumulator unchanged.
- R9: A calc field value other than 0x0 or 0xF makes every transfer leave the accumulator unchanged.
- R10: When control[11] is 1, a read of the accumulator returns its bitwise inverse.
- R11: When control[10] is 1, a read of the accumulator returns it bit-reversed. With both bits set, the read is both inverted and reversed.
- R12: If a store to the accumulator and a qualifying transfer occur in the same cycle, the store wins and the transfer is lost.
- R13: A store to any other offset changes neither register, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register store strobe |
| wr_addr | input | 14 | Store byte address; bits 13:12 select the alias |
| wr_data | input | 32 | Store value or alias mask |
| rd_addr | input | 14 | Read byte address (combinational read) |
| rd_data | output | 32 | Read value, with readout transforms applied to the accumulator |
| xfer_valid | input | 1 | A DMA word is moving this cycle |
| xfer_chan | input | 4 | Channel number of that word |
| xfer_sniff | input | 1 | Snoop flag from the transfer's descriptor |
| xfer_data | input | 32 | The moving word |

## Verification
The bench targets the ALU idioms that depend on alias and accumulate semantics:
- NOT followed by adding 1 must give a negative. A design that swapped SET and CLEAR, or XOR'd the wrong way, returns garbage here.
- The CRC step is checked against a division written in a different form. A reflected or LSB-first step fails that comparison.
- Disqualified transfers are applied one qualifier at a time (wrong channel, no snoop flag, block disabled, undefined calc code). A design that ignored any one qualifier would change the accumulator.
- A store and a qualifying word arrive in the same cycle. A design with the wrong priority would show the sum instead of the seed.
- Inverted and reversed readout are tested apart and together, which catches a swapped or missing transform.

// File: rtl/snp_pkg.sv
package snp_pkg;

    localparam int SNP_DW      = 32;
    localparam int SNP_AW      = 14;
    localparam int SNP_CHAN_W  = 4;
    localparam int SNP_CALC_W  = 4;
    localparam logic [11:0] SNP_OFS_CTRL = 12'h434;
    localparam logic [11:0] SNP_OFS_DATA = 12'h438;
    localparam logic [SNP_DW-1:0] SNP_CRC_POLY = 32'h04C1_1DB7;
    localparam logic [SNP_CALC_W-1:0] SNP_CALC_ADD = 4'hF;
    localparam logic [SNP_CALC_W-1:0] SNP_CALC_CRC = 4'h0;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'b00,
        OP_TOGGLE = 2'b01,
        OP_OR    = 2'b10,
        OP_ANDN  = 2'b11
    } alias_op_e;

    typedef struct packed {
        logic [19:0]           spare_hi;
        logic                  out_inv;
        logic                  out_rev;
        logic                  spare_mid;
        logic [SNP_CALC_W-1:0] calc;
        logic [SNP_CHAN_W-1:0] chan;
        logic                  enable;
    } ctrl_t;

    typedef struct packed {
        logic              to_ctrl;
        logic              to_data;
        alias_op_e         op;
        logic [SNP_DW-1:0] mask;
    } wr_req_t;

    function automatic logic [SNP_DW-1:0] alias_apply(
        input alias_op_e op,
        input logic [SNP_DW-1:0] cur,
        input logic [SNP_DW-1:0] mask
    );
        logic [SNP_DW-1:0] r;
        unique case (op)
            OP_PLAIN:  r = mask;
            OP_TOGGLE: r = cur ^ mask;
            OP_OR:     r = cur | mask;
            OP_ANDN:   r = cur & ~mask;
            default:   r = cur;
        endcase
        return r;
    endfunction

    function automatic logic [SNP_DW-1:0] crc_step(
        input logic [SNP_DW-1:0] crc,
        input logic [SNP_DW-1:0] word
    );
        logic [SNP_DW-1:0] c;
        logic fb;
        c = crc;
        for (int i = SNP_DW - 1; i >= 0; i--) begin
            fb = c[SNP_DW-1] ^ word[i];
            c  = {c[SNP_DW-2:0], 1'b0};
            if (fb) c = c ^ SNP_CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/snp_bus_decode.sv
module snp_bus_decode
    import snp_pkg::*;
(
    input  logic              wr_en,
    input  logic [SNP_AW-1:0] wr_addr,
    input  logic [SNP_DW-1:0] wr_data,
    output wr_req_t           req
);
    logic [11:0] ofs;

    always_comb begin
        ofs         = wr_addr[11:0];
        req.op      = alias_op_e'(wr_addr[SNP_AW-1:SNP_AW-2]);
        req.mask    = wr_data;
        req.to_ctrl = wr_en && (ofs == SNP_OFS_CTRL);
        req.to_data = wr_en && (ofs == SNP_OFS_DATA);
    end

endmodule

// File: rtl/snp_alias_unit.sv
module snp_alias_unit
    import snp_pkg::*;
(
    input  logic              hit,
    input  alias_op_e         op,
    input  logic [SNP_DW-1:0] cur,
    input  logic [SNP_DW-1:0] mask,
    output logic [SNP_DW-1:0] nxt
);
    always_comb begin
        nxt = hit ? alias_apply(op, cur, mask) : cur;
    end
endmodule

// File: rtl/snp_calc_unit.sv
module snp_calc_unit
    import snp_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic              xfer_valid,
    input  logic [SNP_CHAN_W-1:0] xfer_chan,
    input  logic              xfer_sniff,
    input  logic [SNP_DW-1:0] xfer_data,
    input  logic [SNP_DW-1:0] acc,
    output logic              upd,
    output logic [SNP_DW-1:0] acc_nxt
);
    logic qualify;
    logic [SNP_DW-1:0] sum_w;
    logic [SNP_DW-1:0] crc_w;

    always_comb begin
        qualify = xfer_valid && xfer_sniff && ctrl.enable && (xfer_chan == ctrl.chan);
        sum_w   = acc + xfer_data;
        crc_w   = crc_step(acc, xfer_data);
        upd     = 1'b0;
        acc_nxt = acc;
        if (qualify) begin
            if (ctrl.calc == SNP_CALC_ADD) begin
                upd     = 1'b1;
                acc_nxt = sum_w;
            end else if (ctrl.calc == SNP_CALC_CRC) begin
                upd     = 1'b1;
                acc_nxt = crc_w;
            end
        end
    end
endmodule

// File: rtl/snp_read_mux.sv
module snp_read_mux
    import snp_pkg::*;
(
    input  logic [SNP_AW-1:0] rd_addr,
    input  ctrl_t             ctrl,
    input  logic [SNP_DW-1:0] acc,
    output logic [SNP_DW-1:0] rd_data
);
    logic [SNP_DW-1:0] acc_rev;
    logic [SNP_DW-1:0] acc_out;

    for (genvar g = 0; g < SNP_DW; g++) begin : g_rev
        assign acc_rev[g] = acc[SNP_DW-1-g];
    end

    always_comb begin
        acc_out = ctrl.out_rev ? acc_rev : acc;
        if (ctrl.out_inv) acc_out = ~acc_out;
        unique case (rd_addr[11:0])
            SNP_OFS_CTRL: rd_data = ctrl;
            SNP_OFS_DATA: rd_data = acc_out;
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/snoop_accum.sv
module snoop_accum
    import snp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SNP_AW-1:0]     wr_addr,
    input  logic [SNP_DW-1:0]     wr_data,
    input  logic [SNP_AW-1:0]     rd_addr,
    output logic [SNP_DW-1:0]     rd_data,
    input  logic                  xfer_valid,
    input  logic [SNP_CHAN_W-1:0] xfer_chan,
    input  logic                  xfer_sniff,
    input  logic [SNP_DW-1:0]     xfer_data
);
    ctrl_t             ctrl_q;
    logic [SNP_DW-1:0] acc_q;
    wr_req_t           req;
    logic [SNP_DW-1:0] ctrl_nxt;
    logic [SNP_DW-1:0] acc_wr_nxt;
    logic [SNP_DW-1:0] acc_calc_nxt;
    logic              calc_upd;

    snp_bus_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req)
    );

    snp_alias_unit u_ctrl_alias (
        .hit  (req.to_ctrl),
        .op   (req.op),
        .cur  (ctrl_q),
        .mask (req.mask),
        .nxt  (ctrl_nxt)
    );

    snp_alias_unit u_acc_alias (
        .hit  (req.to_data),
        .op   (req.op),
        .cur  (acc_q),
        .mask (req.mask),
        .nxt  (acc_wr_nxt)
    );

    snp_calc_unit u_calc (
        .ctrl       (ctrl_q),
        .xfer_valid (xfer_valid),
        .xfer_chan  (xfer_chan),
        .xfer_sniff (xfer_sniff),
        .xfer_data  (xfer_data),
        .acc        (acc_q),
        .upd        (calc_upd),
        .acc_nxt    (acc_calc_nxt)
    );

    snp_read_mux u_rd (
        .rd_addr (rd_addr),
        .ctrl    (ctrl_q),
        .acc     (acc_q),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            acc_q  <= '0;
        end else begin
            ctrl_q <= ctrl_t'(ctrl_nxt);
            if (req.to_data)
                acc_q <= acc_wr_nxt;
            else if (calc_upd)
                acc_q <= acc_calc_nxt;
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!xfer_valid && !wr_en) |=> $stable(acc_q) && $stable(ctrl_q)); // R8

    AST_PLAIN_SEED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == {2'b00, SNP_OFS_DATA}) |=> acc_q == $past(wr_data)); // R12

    AST_CTRL_OR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == {2'b10, SNP_OFS_CTRL}) |=> ctrl_q == ($past(ctrl_q) | $past(wr_data))); // R3

    AST_ADD_STEP: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && xfer_sniff && ctrl_q.enable && xfer_chan == ctrl_q.chan &&
         ctrl_q.calc == 4'hF && !wr_en) |=> acc_q == $past(acc_q) + $past(xfer_data)); // R6

    AST_BAD_CALC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.calc != 4'hF && ctrl_q.calc != 4'h0 && !wr_en) |=> $stable(acc_q)); // R9

endmodule

// File: tb/tb_snoop_accum.sv
module tb_snoop_accum;

    localparam logic [13:0] A_CTRL = 14'h0434;
    localparam logic [13:0] A_DATA = 14'h0438;
    localparam logic [13:0] A_TGL  = 14'h1000;
    localparam logic [13:0] A_OR   = 14'h2000;
    localparam logic [13:0] A_ANDN = 14'h3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [13:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [13:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        xfer_valid = 1'b0;
    logic [3:0]  xfer_chan = '0;
    logic        xfer_sniff = 1'b0;
    logic [31:0] xfer_data = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [13:0] addr;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    logic [31:0] m_ctrl;
    logic [31:0] m_acc;

    always #4 clk = ~clk;

    snoop_accum dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .xfer_valid(xfer_valid), .xfer_chan(xfer_chan),
        .xfer_sniff(xfer_sniff), .xfer_data(xfer_data)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] c0, input logic [31:0] d);
        logic [31:0] c;
        c = c0 ^ d;
        for (int k = 0; k < 32; k++)
            c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
        return c;
    endfunction

    function automatic logic [31:0] ref_view(input logic [31:0] ctl, input logic [31:0] a);
        logic [31:0] v;
        v = a;
        if (ctl[10]) for (int k = 0; k < 32; k++) v[k] = a[31-k];
        if (ctl[11]) v = ~v;
        return v;
    endfunction

    task automatic store(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic snoop(input logic [3:0] ch, input logic sn, input logic [31:0] d);
        @(negedge clk);
        xfer_valid = 1'b1; xfer_chan = ch; xfer_sniff = sn; xfer_data = d;
        @(negedge clk);
        xfer_valid = 1'b0; xfer_sniff = 1'b0;
    endtask

    task automatic expect_rd(input logic [13:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic check_acc(input string tag);
        expect_rd(A_DATA, ref_view(m_ctrl, m_acc), tag);
    endtask

    initial begin : monitor
        exp_item_t it;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q[0];
            @(negedge clk);
            rd_addr = it.addr;
            #1;
            n_vec++;
            if (rd_data !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%h got=%h exp=%h", it.tag, it.addr, rd_data, it.exp);
            end
            void'(sb_q.pop_front());
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_ctrl = '0; m_acc = '0;
        expect_rd(A_CTRL, 32'h0, "R1 ctrl after reset");
        expect_rd(A_DATA, 32'h0, "R1 acc after reset");

        // R2 plain stores: enable=1, chan=3, calc=F
        store(A_DATA, 32'h1234_5678); m_acc = 32'h1234_5678;
        check_acc("R2 seed");
        store(A_CTRL, 32'h0000_01E7); m_ctrl = 32'h0000_01E7;
        expect_rd(A_CTRL, m_ctrl, "R2 ctrl plain");

        // R3 / R4 / R5 aliases on accumulator
        store(A_OR | A_DATA, 32'h0F0F_0000); m_acc |= 32'h0F0F_0000;
        check_acc("R3 set alias");
        store(A_ANDN | A_DATA, 32'hFFFF_0000); m_acc &= ~32'hFFFF_0000;
        check_acc("R4 clear alias");
        store(A_TGL | A_DATA, 32'hFFFF_FFFF); m_acc = ~m_acc;
        check_acc("R5 xor NOT");
        store(A_TGL | A_CTRL, 32'h0000_0200); m_ctrl ^= 32'h0000_0200;
        expect_rd(A_CTRL, m_ctrl, "R5 xor ctrl");
        store(A_TGL | A_CTRL, 32'h0000_0200); m_ctrl ^= 32'h0000_0200;

        // R6 add mode
        store(A_DATA, 32'h0000_0010); m_acc = 32'h10;
        snoop(4'd3, 1'b1, 32'h0000_0005); m_acc += 32'h5;
        check_acc("R6 add");
        snoop(4'd3, 1'b1, 32'hFFFF_FFF0); m_acc += 32'hFFFF_FFF0;
        check_acc("R6 add wrap");
        store(A_DATA, 32'd7); store(A_TGL | A_DATA, 32'hFFFF_FFFF);
        snoop(4'd3, 1'b1, 32'd1); m_acc = 32'hFFFF_FFF9;
        check_acc("R6 negate");

        // R8 disqualified transfers
        snoop(4'd2, 1'b1, 32'd100);
        check_acc("R8 wrong channel");
        snoop(4'd3, 1'b0, 32'd100);
        check_acc("R8 no sniff flag");
        store(A_ANDN | A_CTRL, 32'h1); m_ctrl &= ~32'h1;
        snoop(4'd3, 1'b1, 32'd100);
        check_acc("R8 disabled");
        store(A_OR | A_CTRL, 32'h1); m_ctrl |= 32'h1;

        // R7 CRC mode
        store(A_ANDN | A_CTRL, 32'h0000_01E0); m_ctrl &= ~32'h0000_01E0;
        store(A_DATA, 32'hFFFF_FFFF); m_acc = 32'hFFFF_FFFF;
        snoop(4'd3, 1'b1, 32'hDEAD_BEEF); m_acc = ref_crc(m_acc, 32'hDEAD_BEEF);
        check_acc("R7 crc step 1");
        snoop(4'd3, 1'b1, 32'h0000_0001); m_acc = ref_crc(m_acc, 32'h1);
        check_acc("R7 crc step 2");

        // R9 undefined calc code 0x5
        store(A_OR | A_CTRL, 32'h0000_00A0); m_ctrl |= 32'h0000_00A0;
        snoop(4'd3, 1'b1, 32'h1111_1111);
        check_acc("R9 bad calc holds");
        store(A_OR | A_CTRL, 32'h0000_01E0); m_ctrl |= 32'h0000_01E0;

        // R10 / R11 readout transforms
        store(A_DATA, 32'h8000_00F1); m_acc = 32'h8000_00F1;
        store(A_OR | A_CTRL, 32'h800); m_ctrl |= 32'h800;
        expect_rd(A_DATA, 32'h7FFF_FF0E, "R10 invert");
        store(A_TGL | A_CTRL, 32'hC00); m_ctrl ^= 32'hC00;
        expect_rd(A_DATA, 32'h8F00_0001, "R11 reverse");
        store(A_OR | A_CTRL, 32'h800); m_ctrl |= 32'h800;
        expect_rd(A_DATA, 32'h70FF_FFFE, "R11 reverse+invert");
        store(A_ANDN | A_CTRL, 32'hC00); m_ctrl &= ~32'hC00;

        // R12 store beats snoop in same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_DATA; wr_data = 32'h0000_0ABC;
        xfer_valid = 1'b1; xfer_chan = 4'd3; xfer_sniff = 1'b1; xfer_data = 32'h100;
        @(negedge clk);
        wr_en = 1'b0; xfer_valid = 1'b0; xfer_sniff = 1'b0;
        m_acc = 32'h0000_0ABC;
        check_acc("R12 store priority");

        // R13 unmapped offset
        store(14'h0100, 32'hFFFF_FFFF);
        check_acc("R13 acc untouched");
        expect_rd(A_CTRL, m_ctrl, "R13 ctrl untouched");
        expect_rd(14'h0100, 32'h0, "R13 unmapped read");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule